// File: doc/BRIEF.md
# Processor Mode and Exception Controller

This block holds the operating mode of a small processor core and decides every change to it. Each rising clock edge it looks at the reset line, the interrupt lines, the exception strobes and any mode-change write from software. It then picks at most one cause and loads the new mode, the interrupt masks and a one-cycle record of the exception it accepted.

Seven modes exist, and exactly one is active at a time. Every mode except User is privileged. System mode is privileged but works with the User register view. Each exception source enters a mode of its own and raises its interrupt masks. Software leaves an exception mode through a privileged write of a new mode code. A mode-change write made while in User mode is dropped without effect.

Top module: `cpu_mode_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next state is Supervisor mode (`10011`) with `priv_o`=1, `exc_taken_o`=0 and `exc_vec_o`=0. Both the fast and the normal interrupt masks are set.
- R2: `mode_o` only ever holds one of seven codes: User `10000`, FIQ `10001`, IRQ `10010`, Supervisor `10011`, Abort `10111`, Undefined `11011`, System `11111`.
- R3: `abort_stb` sampled high enters Abort mode (`10111`) with vector 3 and sets the normal interrupt mask.
- R4: `fiq_req` sampled high while the fast mask is clear enters FIQ mode (`10001`) with vector 7 and sets both masks.
- R5: `irq_req` sampled high while the normal mask is clear enters IRQ mode (`10010`) with vector 6 and sets the normal mask.
- R6: `undef_stb` enters Undefined mode (`11011`) with vector 1. `swi_stb` enters Supervisor mode (`10011`) with vector 2. Both set the normal mask.
- R7: When several causes are present in one cycle, the order from highest to lowest is reset, abort, fast interrupt, normal interrupt, undefined, software interrupt. An accepted exception discards a mode write made in the same cycle.
- R8: An interrupt request whose mask is set causes no entry, no pulse and no mode change.
- R9: `exc_taken_o` is high for exactly the cycle after each edge at which an exception was accepted. `exc_vec_o` carries that exception's vector in that cycle and is 0 in every other cycle.
- R10: `priv_o` is 0 when the mode is User and 1 in every other mode.
- R11: A write (`mode_wr_valid`=1) made from a privileged mode with a legal code loads that code at the next edge. A write with any other code is ignored.
- R12: A write made while in User mode is ignored, whatever its code.
- R13: An accepted write to User or System clears both interrupt masks. An accepted write to any other mode leaves the masks as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fiq_req | input | 1 | Fast interrupt request, level |
| irq_req | input | 1 | Normal interrupt request, level |
| swi_stb | input | 1 | Software interrupt strobe |
| abort_stb | input | 1 | Failed or disallowed memory access strobe |
| undef_stb | input | 1 | Unexecutable instruction strobe |
| mode_wr_valid | input | 1 | Software mode-change write valid |
| mode_wr_code | input | 5 | Requested mode code |
| mode_o | output | 5 | Current mode code |
| priv_o | output | 1 | Current mode is privileged |
| exc_taken_o | output | 1 | One-cycle pulse when an exception was accepted |
| exc_vec_o | output | 3 | Vector index of the accepted exception |

## Verification
All four outputs are registered, so each one is due in the cycle right after the rising edge that sampled its cause. The bench drives inputs on the falling edge. A behavioural reference model updates at the rising edge from the same input values, and the bench compares mode, privilege, pulse and vector at the next falling edge. The check therefore never looks at a value in the cycle where it changes. The interrupt masks cannot be seen directly. They are checked instead through whether a later request enters its mode, in directed sequences and in a long pseudo-random run.

// File: rtl/cpu_mode_pkg.sv
// Package: mode codes, vector indices and the arbiter's selection record
// shared by the mode controller and its sub-blocks.
package cpu_mode_pkg;
    localparam int MODE_W = 5;
    localparam int VEC_W  = 3;

    localparam logic [MODE_W-1:0] M_USR = 5'b10000;
    localparam logic [MODE_W-1:0] M_FIQ = 5'b10001;
    localparam logic [MODE_W-1:0] M_IRQ = 5'b10010;
    localparam logic [MODE_W-1:0] M_SVC = 5'b10011;
    localparam logic [MODE_W-1:0] M_ABT = 5'b10111;
    localparam logic [MODE_W-1:0] M_UND = 5'b11011;
    localparam logic [MODE_W-1:0] M_SYS = 5'b11111;

    localparam logic [VEC_W-1:0] V_NONE = 3'd0;
    localparam logic [VEC_W-1:0] V_UND  = 3'd1;
    localparam logic [VEC_W-1:0] V_SWI  = 3'd2;
    localparam logic [VEC_W-1:0] V_ABT  = 3'd3;
    localparam logic [VEC_W-1:0] V_IRQ  = 3'd6;
    localparam logic [VEC_W-1:0] V_FIQ  = 3'd7;

    // One accepted exception: whether any was taken, where it goes,
    // its vector and whether it also masks fast interrupts.
    typedef struct packed {
        logic              take;
        logic [MODE_W-1:0] mode;
        logic [VEC_W-1:0]  vec;
        logic              set_fmask;
    } exc_sel_t;

    // True for the seven defined mode codes only.
    function automatic logic mode_is_legal(input logic [MODE_W-1:0] m);
        return (m == M_USR) || (m == M_FIQ) || (m == M_IRQ) || (m == M_SVC) ||
               (m == M_ABT) || (m == M_UND) || (m == M_SYS);
    endfunction
endpackage

// File: rtl/exc_arbiter.sv
// Module: exc_arbiter
// Picks the single highest-priority exception among abort, fast interrupt,
// normal interrupt, undefined and software interrupt. Interrupt lines are
// qualified by their masks. Assumes reset is handled by the caller, which
// overrides this choice. Purely combinational.
module exc_arbiter
    import cpu_mode_pkg::*;
(
    input  logic     abort_stb,
    input  logic     fiq_req,
    input  logic     irq_req,
    input  logic     undef_stb,
    input  logic     swi_stb,
    input  logic     fmask,
    input  logic     imask,
    output exc_sel_t sel
);
    localparam int NSRC = 5;

    logic [NSRC-1:0]        hit;
    logic [NSRC-1:0][MODE_W-1:0] tgt_mode;
    logic [NSRC-1:0][VEC_W-1:0]  tgt_vec;

    // Source table in priority order, index 0 highest.
    always_comb begin
        hit[0] = abort_stb;            tgt_mode[0] = M_ABT; tgt_vec[0] = V_ABT;
        hit[1] = fiq_req && !fmask;    tgt_mode[1] = M_FIQ; tgt_vec[1] = V_FIQ;
        hit[2] = irq_req && !imask;    tgt_mode[2] = M_IRQ; tgt_vec[2] = V_IRQ;
        hit[3] = undef_stb;            tgt_mode[3] = M_UND; tgt_vec[3] = V_UND;
        hit[4] = swi_stb;              tgt_mode[4] = M_SVC; tgt_vec[4] = V_SWI;
    end

    // Fixed-priority pick: scan from lowest to highest so the highest wins.
    always_comb begin
        sel = '{take: 1'b0, mode: M_SVC, vec: V_NONE, set_fmask: 1'b0};
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (hit[i]) begin
                sel.take      = 1'b1;
                sel.mode      = tgt_mode[i];
                sel.vec       = tgt_vec[i];
                sel.set_fmask = (i == 1);
            end
        end
    end
endmodule

// File: rtl/mode_write_filter.sv
// Module: mode_write_filter
// Decides whether a software mode-change write is accepted. It must come
// from a privileged mode and carry one of the seven legal codes. Also flags
// writes that reopen interrupts. Assumes the caller gives exceptions
// precedence over the write. Purely combinational.
module mode_write_filter
    import cpu_mode_pkg::*;
(
    input  logic [MODE_W-1:0] cur_mode,
    input  logic              wr_valid,
    input  logic [MODE_W-1:0] wr_code,
    output logic              accept,
    output logic              clr_masks
);
    // Gate the write on privilege and code legality.
    always_comb begin
        accept    = wr_valid && (cur_mode != M_USR) && mode_is_legal(wr_code);
        clr_masks = accept && ((wr_code == M_USR) || (wr_code == M_SYS));
    end
endmodule

// File: rtl/cpu_mode_ctrl.sv
// Module: cpu_mode_ctrl (top)
// Holds the current mode, the two interrupt masks and a one-cycle record of
// the accepted exception. Reset beats exceptions, and exceptions beat
// software writes. Assumes strobes are single-cycle and synchronous to clk.
// Synchronous active-low reset.
module cpu_mode_ctrl
    import cpu_mode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fiq_req,
    input  logic              irq_req,
    input  logic              swi_stb,
    input  logic              abort_stb,
    input  logic              undef_stb,
    input  logic              mode_wr_valid,
    input  logic [MODE_W-1:0] mode_wr_code,
    output logic [MODE_W-1:0] mode_o,
    output logic              priv_o,
    output logic              exc_taken_o,
    output logic [VEC_W-1:0]  exc_vec_o
);
    logic [MODE_W-1:0] mode_q;
    logic              fmask_q, imask_q;
    logic              taken_q;
    logic [VEC_W-1:0]  vec_q;

    exc_sel_t sel;
    logic     wr_accept, wr_clr;

    exc_arbiter u_arb (
        .abort_stb (abort_stb),
        .fiq_req   (fiq_req),
        .irq_req   (irq_req),
        .undef_stb (undef_stb),
        .swi_stb   (swi_stb),
        .fmask     (fmask_q),
        .imask     (imask_q),
        .sel       (sel)
    );

    mode_write_filter u_wrf (
        .cur_mode  (mode_q),
        .wr_valid  (mode_wr_valid),
        .wr_code   (mode_wr_code),
        .accept    (wr_accept),
        .clr_masks (wr_clr)
    );

    // Mode and mask update: reset, then an exception, then a software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= M_SVC;
            fmask_q <= 1'b1;
            imask_q <= 1'b1;
        end else if (sel.take) begin
            mode_q  <= sel.mode;
            imask_q <= 1'b1;
            if (sel.set_fmask) fmask_q <= 1'b1;
        end else if (wr_accept) begin
            mode_q <= mode_wr_code;
            if (wr_clr) begin
                fmask_q <= 1'b0;
                imask_q <= 1'b0;
            end
        end
    end

    // Exception record: pulse and vector for one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken_q <= 1'b0;
            vec_q   <= V_NONE;
        end else begin
            taken_q <= sel.take;
            vec_q   <= sel.take ? sel.vec : V_NONE;
        end
    end

    // Output drive.
    always_comb begin
        mode_o      = mode_q;
        priv_o      = (mode_q != M_USR);
        exc_taken_o = taken_q;
        exc_vec_o   = vec_q;
    end

    // R2: only defined codes are ever held.
    p_mode_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_is_legal(mode_o));

    // R3: an abort strobe always lands in Abort mode with vector 3.
    p_abort_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        abort_stb |=> (mode_o == M_ABT) && exc_taken_o && (exc_vec_o == V_ABT));

    // R4: an unmasked fast request without abort enters FIQ and masks both.
    p_fiq_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fiq_req && !fmask_q && !abort_stb) |=> (mode_o == M_FIQ) && fmask_q && imask_q);

    // R8: a masked normal request alone changes nothing.
    p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (imask_q && !abort_stb && !(fiq_req && !fmask_q) && !undef_stb && !swi_stb
         && !mode_wr_valid) |=> $stable(mode_o) && !exc_taken_o);

    // R9: the vector is zero whenever no exception is being reported.
    p_vec_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_taken_o |-> (exc_vec_o == V_NONE));

    // R12: a write from User without any exception leaves User mode in place.
    p_user_write_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_o == M_USR) && !sel.take) |=> (mode_o == M_USR));
endmodule

// File: tb/cpu_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module cpu_mode_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fiq_req = 0, irq_req = 0, swi_stb = 0, abort_stb = 0, undef_stb = 0;
    logic       mode_wr_valid = 0;
    logic [4:0] mode_wr_code = 5'b0;
    logic [4:0] mode_o;
    logic       priv_o, exc_taken_o;
    logic [2:0] exc_vec_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model state.
    int m_mode = 5'b10011;
    bit m_fm = 1, m_im = 1, m_pulse = 0;
    int m_vec = 0;

    always #2 clk = ~clk;

    cpu_mode_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .fiq_req(fiq_req), .irq_req(irq_req),
        .swi_stb(swi_stb), .abort_stb(abort_stb), .undef_stb(undef_stb),
        .mode_wr_valid(mode_wr_valid), .mode_wr_code(mode_wr_code),
        .mode_o(mode_o), .priv_o(priv_o), .exc_taken_o(exc_taken_o),
        .exc_vec_o(exc_vec_o)
    );

    function automatic bit legal(int c);
        return c == 'h10 || c == 'h11 || c == 'h12 || c == 'h13 ||
               c == 'h17 || c == 'h1B || c == 'h1F;
    endfunction

    // Behavioural next-state of the reference, from the inputs at the edge.
    task automatic model_edge();
        if (!rst_n) begin
            m_mode = 'h13; m_fm = 1; m_im = 1; m_pulse = 0; m_vec = 0;
        end else begin
            m_pulse = 1;
            if (abort_stb)              begin m_mode = 'h17; m_im = 1; m_vec = 3; end
            else if (fiq_req && !m_fm)  begin m_mode = 'h11; m_fm = 1; m_im = 1; m_vec = 7; end
            else if (irq_req && !m_im)  begin m_mode = 'h12; m_im = 1; m_vec = 6; end
            else if (undef_stb)         begin m_mode = 'h1B; m_im = 1; m_vec = 1; end
            else if (swi_stb)           begin m_mode = 'h13; m_im = 1; m_vec = 2; end
            else begin
                m_pulse = 0; m_vec = 0;
                if (mode_wr_valid && m_mode != 'h10 && legal(int'(mode_wr_code))) begin
                    m_mode = int'(mode_wr_code);
                    if (m_mode == 'h10 || m_mode == 'h1F) begin m_fm = 0; m_im = 0; end
                end
            end
        end
    endtask

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One cycle: edge, model update, compare at the falling edge.
    task automatic step(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(tag, "mode", int'(mode_o), m_mode);
        chk("R10", "priv", int'(priv_o), (m_mode != 'h10) ? 1 : 0);
        chk("R9", "pulse", int'(exc_taken_o), int'(m_pulse));
        chk("R9", "vector", int'(exc_vec_o), m_vec);
    endtask

    task automatic idle();
        fiq_req = 0; irq_req = 0; swi_stb = 0; abort_stb = 0; undef_stb = 0;
        mode_wr_valid = 0; mode_wr_code = 0;
    endtask

    task automatic wr(logic [4:0] c);
        idle(); mode_wr_valid = 1; mode_wr_code = c;
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        rst_n = 0; idle(); step("R1"); step("R1");
        chk("R1", "mode after reset", int'(mode_o), 'h13);
        rst_n = 1;
        idle(); fiq_req = 1; irq_req = 1; step("R8");
        chk("R8", "no pulse while masked", int'(exc_taken_o), 0);
        wr(5'b01010); step("R11");
        chk("R11", "illegal code kept SVC", int'(mode_o), 'h13);
        wr(5'b11111); step("R13");
        idle(); irq_req = 1; step("R5");
        chk("R5", "IRQ entered", int'(mode_o), 'h12);
        idle(); fiq_req = 1; step("R4");
        chk("R4", "FIQ from IRQ", int'(mode_o), 'h11);
        idle(); fiq_req = 1; irq_req = 1; step("R8");
        wr(5'b11011); step("R13");
        idle(); irq_req = 1; step("R13");
        chk("R13", "masks kept after write to UND", int'(mode_o), 'h1B);
        wr(5'b10000); step("R11");
        chk("R12", "priv low in User", int'(priv_o), 0);
        wr(5'b10011); step("R12");
        chk("R12", "User write ignored", int'(mode_o), 'h10);
        idle(); abort_stb = 1; fiq_req = 1; irq_req = 1; undef_stb = 1; swi_stb = 1;
        mode_wr_valid = 1; mode_wr_code = 5'b11111; step("R7");
        chk("R3", "abort vector", int'(exc_vec_o), 3);
        wr(5'b11111); step("R7");
        idle(); fiq_req = 1; irq_req = 1; undef_stb = 1; step("R7");
        chk("R4", "FIQ vector", int'(exc_vec_o), 7);
        wr(5'b11111); step("R11");
        idle(); undef_stb = 1; swi_stb = 1; mode_wr_valid = 1; mode_wr_code = 5'b10000;
        step("R6");
        chk("R6", "undefined beats SWI", int'(mode_o), 'h1B);
        idle(); swi_stb = 1; step("R6");
        chk("R6", "SWI vector", int'(exc_vec_o), 2);
        idle(); step("R9");
        chk("R9", "pulse ended", int'(exc_taken_o), 0);
        idle(); rst_n = 0; abort_stb = 1; step("R1");
        rst_n = 1;
        for (int i = 0; i < 4000; i++) begin
            int r;
            idle();
            r = $urandom_range(0, 99);
            fiq_req   = (r % 7) == 0;
            irq_req   = (r % 5) == 0;
            abort_stb = $urandom_range(0, 29) == 0;
            undef_stb = $urandom_range(0, 24) == 0;
            swi_stb   = $urandom_range(0, 19) == 0;
            mode_wr_valid = $urandom_range(0, 2) == 0;
            case ($urandom_range(0, 7))
                0: mode_wr_code = 5'b10000; 1: mode_wr_code = 5'b10001;
                2: mode_wr_code = 5'b10010; 3: mode_wr_code = 5'b10011;
                4: mode_wr_code = 5'b10111; 5: mode_wr_code = 5'b11011;
                6: mode_wr_code = 5'b11111;
                default: mode_wr_code = 5'($urandom_range(0, 31));
            endcase
            rst_n = $urandom_range(0, 299) != 0;
            step("R7");
            chk("R2", "legal code", legal(int'(mode_o)) ? 1 : 0, 1);
        end
        rst_n = 1;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule